// File: doc/BRIEF.md
# Lane-wise masked high-word shuffler

This block is a registered SIMD permute datapath for a 512-bit vector register path. The vector is split into 128-bit lanes of eight 16-bit words. In every active lane, the four low words pass through unchanged. The four high words are rebuilt from that lane's own four high words. An 8-bit immediate picks which word goes where, and the same immediate is used in every lane. Selection never crosses a lane boundary, and one source word may be copied into several result positions.

An encoding-mode input sets how the result is written back:

- **Legacy mode** works on the bottom lane only and leaves every bit above it at its old destination value.
- **Zero-extending mode** works on 128 or 256 bits and clears every bit at or above that length.
- **Masked mode** works on 128, 256 or 512 bits. It applies a per-word write mask, either merging or zeroing, and it also clears every bit at or above the length.

Bad field combinations raise an illegal-instruction flag. In that case the old destination value is returned and the valid output stays low. One operation is accepted per cycle, and each result appears one cycle after its input.

Top module: `hiword_permuter`

## Requirements
- R1: In every active lane, the result's low 64 bits equal the source's low 64 bits of that lane, unless masking replaces a word.
- R2: Result words 4, 5, 6 and 7 of a lane take the lane's source word 4+sel, where sel is the 2-bit field imm[1:0], imm[3:2], imm[5:4] and imm[7:6] respectively.
- R3: The same immediate applies to every active lane, no word is taken from another lane, and a source word may fill several result words.
- R4: The vector length code vlen selects the length: 2'b00 is 128 bits, 2'b01 is 256 bits and 2'b10 is 512 bits. In zero-extending mode (enc_mode 2'b01) and masked mode (enc_mode 2'b10), all result bits at or above the length are 0.
- R5: In legacy mode (enc_mode 2'b00) only lane 0 (bits [127:0]) is computed and bits [511:128] keep old_dst. In this mode vlen, len_bit, rsv_field and the mask inputs have no effect.
- R6: In masked mode with mask_en=1, a 0 in mask bit j makes result word j (bits [16j+15:16j]) keep old_dst when mask_zero=0, or become 0 when mask_zero=1. A 1 in mask bit j gives the shuffled word.
- R7: When mask_en=0, or when the mode is not masked mode, mask and mask_zero have no effect and every active word takes its shuffled value.
- R8: The operation is illegal when any of the following holds:
  - enc_mode is 2'b11;
  - the mode is not legacy and rsv_field is not 4'b1111;
  - the mode is not legacy and vlen is 2'b11;
  - the mode is zero-extending and vlen is 2'b10;
  - the mode is zero-extending, vlen is 2'b00 and len_bit is 1.
- R9: One cycle after an illegal operation is presented, res_illegal is 1, res_valid is 0 and res_data equals that operation's old_dst.
- R10: A legal operation presented with in_valid=1 gives res_valid=1 and its result on res_data one cycle later. A cycle without in_valid gives res_valid=0 and res_illegal=0 one cycle later, and res_data holds its value.
- R11: While rst_n is low, res_valid, res_illegal and res_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| src | input | 512 | Source vector |
| old_dst | input | 512 | Current destination value |
| imm | input | 8 | Four 2-bit word selectors |
| vlen | input | 2 | Vector length code |
| len_bit | input | 1 | Length bit of the zero-extending encoding |
| mask | input | 32 | Per-word write mask |
| mask_en | input | 1 | Apply the write mask (masked mode only) |
| mask_zero | input | 1 | 1 zeroes masked-off words, 0 merges old_dst |
| enc_mode | input | 2 | 00 legacy, 01 zero-extending, 10 masked, 11 illegal |
| rsv_field | input | 4 | Reserved register-specifier field |
| res_valid | output | 1 | Legal result available |
| res_data | output | 512 | Result vector |
| res_illegal | output | 1 | The previous operation was illegal |

## Verification
The bench sweeps all 256 immediates in every mode and length. Source words are made distinct, so a selector that is decoded in the wrong order, or that reaches across into a neighbouring lane, shows up as a wrong word. A duplicate-selector pattern catches a design that assumes the permutation has no repeats. Merge and zero masking are run with random masks alongside runs where the mask is disabled: a design that applies the mask in the wrong mode, or that confuses merging with zeroing, corrupts single words. The region above the vector length is checked against old_dst in legacy mode and against zero in the other modes, which exposes a design that clears or keeps the wrong span. Every illegal field combination is presented, to catch a design that still reports valid or writes shuffled data.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  typedef enum logic [1:0] {
    ENC_LEGACY = 2'b00,
    ENC_ZEXT   = 2'b01,
    ENC_MASKED = 2'b10,
    ENC_BAD    = 2'b11
  } enc_mode_e;

  localparam logic [3:0] RSV_OK = 4'b1111;
endpackage

// File: rtl/hwp_lane_shuffle.sv
module hwp_lane_shuffle #(
  parameter int WORD_W = 16
) (
  input  logic [8*WORD_W-1:0] lane_in,
  input  logic [7:0]          imm,
  output logic [8*WORD_W-1:0] lane_out
);
  localparam int HALF_W = 4 * WORD_W;

  // low quadword passes straight through
  assign lane_out[HALF_W-1:0] = lane_in[HALF_W-1:0];

  for (genvar k = 0; k < 4; k++) begin : g_hi
    logic [1:0] sel;
    assign sel = imm[2*k +: 2];
    assign lane_out[HALF_W + k*WORD_W +: WORD_W] =
      lane_in[HALF_W + int'(sel)*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/hwp_decode_chk.sv
module hwp_decode_chk
  import hwp_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic [1:0]           enc_mode,
  input  logic [1:0]           vlen,
  input  logic                 len_bit,
  input  logic [3:0]           rsv_field,
  input  logic                 mask_en,
  output logic                 illegal,
  output logic [NUM_LANES-1:0] lane_on,
  output logic                 keep_above,
  output logic                 mask_act
);
  logic is_legacy, is_zext, is_masked;

  always_comb begin
    is_legacy = (enc_mode == ENC_LEGACY);
    is_zext   = (enc_mode == ENC_ZEXT);
    is_masked = (enc_mode == ENC_MASKED);

    illegal = 1'b0;
    if (enc_mode == ENC_BAD) illegal = 1'b1;
    if (!is_legacy && rsv_field != RSV_OK) illegal = 1'b1;
    if (!is_legacy && vlen == 2'b11) illegal = 1'b1;
    if (is_zext && vlen == 2'b10) illegal = 1'b1;
    if (is_zext && vlen == 2'b00 && len_bit) illegal = 1'b1;
    if (!is_legacy && (32'd1 << vlen) > NUM_LANES) illegal = 1'b1;

    for (int l = 0; l < NUM_LANES; l++) begin
      if (is_legacy) lane_on[l] = (l == 0);
      else           lane_on[l] = (32'(l) < (32'd1 << vlen));
    end

    keep_above = is_legacy;
    mask_act   = is_masked && mask_en;
  end
endmodule

// File: rtl/hwp_word_select.sv
module hwp_word_select #(
  parameter int WORD_W    = 16,
  parameter int NUM_LANES = 4
) (
  input  logic [NUM_LANES*8*WORD_W-1:0] shuf,
  input  logic [NUM_LANES*8*WORD_W-1:0] old_dst,
  input  logic [NUM_LANES*8-1:0]        mask,
  input  logic [NUM_LANES-1:0]          lane_on,
  input  logic                          keep_above,
  input  logic                          mask_act,
  input  logic                          mask_zero,
  output logic [NUM_LANES*8*WORD_W-1:0] merged
);
  localparam int WPL   = 8;
  localparam int WORDS = NUM_LANES * WPL;

  for (genvar j = 0; j < WORDS; j++) begin : g_word
    localparam int LANE = j / WPL;
    logic [WORD_W-1:0] s_w, o_w;
    assign s_w = shuf[j*WORD_W +: WORD_W];
    assign o_w = old_dst[j*WORD_W +: WORD_W];
    assign merged[j*WORD_W +: WORD_W] =
      !lane_on[LANE]          ? (keep_above ? o_w : '0) :
      (!mask_act || mask[j])  ? s_w :
      mask_zero               ? '0 : o_w;
  end
endmodule

// File: rtl/hiword_permuter.sv
module hiword_permuter
  import hwp_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_LANES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [NUM_LANES*8*WORD_W-1:0] src,
  input  logic [NUM_LANES*8*WORD_W-1:0] old_dst,
  input  logic [7:0]                    imm,
  input  logic [1:0]                    vlen,
  input  logic                          len_bit,
  input  logic [NUM_LANES*8-1:0]        mask,
  input  logic                          mask_en,
  input  logic                          mask_zero,
  input  logic [1:0]                    enc_mode,
  input  logic [3:0]                    rsv_field,
  output logic                          res_valid,
  output logic [NUM_LANES*8*WORD_W-1:0] res_data,
  output logic                          res_illegal
);
  localparam int LANE_W = 8 * WORD_W;
  localparam int DATA_W = NUM_LANES * LANE_W;

  logic [DATA_W-1:0]    shuf, merged, data_d;
  logic [NUM_LANES-1:0] lane_on;
  logic                 illegal, keep_above, mask_act;
  logic                 valid_d, ill_d;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    hwp_lane_shuffle #(.WORD_W(WORD_W)) u_lane (
      .lane_in  (src[l*LANE_W +: LANE_W]),
      .imm      (imm),
      .lane_out (shuf[l*LANE_W +: LANE_W])
    );
  end

  hwp_decode_chk #(.NUM_LANES(NUM_LANES)) u_dec (
    .enc_mode   (enc_mode),
    .vlen       (vlen),
    .len_bit    (len_bit),
    .rsv_field  (rsv_field),
    .mask_en    (mask_en),
    .illegal    (illegal),
    .lane_on    (lane_on),
    .keep_above (keep_above),
    .mask_act   (mask_act)
  );

  hwp_word_select #(.WORD_W(WORD_W), .NUM_LANES(NUM_LANES)) u_sel (
    .shuf       (shuf),
    .old_dst    (old_dst),
    .mask       (mask),
    .lane_on    (lane_on),
    .keep_above (keep_above),
    .mask_act   (mask_act),
    .mask_zero  (mask_zero),
    .merged     (merged)
  );

  // next-state
  always_comb begin
    valid_d = in_valid && !illegal;
    ill_d   = in_valid && illegal;
    data_d  = res_data;
    if (in_valid) data_d = illegal ? old_dst : merged;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_illegal <= 1'b0;
      res_data    <= '0;
    end else begin
      res_valid   <= valid_d;
      res_illegal <= ill_d;
      if (in_valid) res_data <= data_d;
    end
  end

  // R1: low quadword of lane 0 passes through when no mask is active
  p_low_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !illegal && !mask_act |=> res_data[63:0] == $past(src[63:0]));

  // R2: result word 4 of lane 0 follows selector imm[1:0]
  p_sel_word4_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !illegal && !mask_act
    |=> res_data[4*WORD_W +: WORD_W] == $past(src[(4 + int'(imm[1:0]))*WORD_W +: WORD_W]));

  // R5: legacy mode keeps everything above lane 0
  p_legacy_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && enc_mode == ENC_LEGACY
    |=> res_data[DATA_W-1:LANE_W] == $past(old_dst[DATA_W-1:LANE_W]));

  // R6: zeroing mask clears a masked-off word 0
  p_zero_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !illegal && mask_act && mask_zero && !mask[0]
    |=> res_data[WORD_W-1:0] == '0);

  // R9: illegal returns old destination
  p_illegal_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && illegal |=> res_illegal && !res_valid && res_data == $past(old_dst));

  // R10: valid only follows an accepted input
  p_valid_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !res_illegal);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid && !res_illegal && $stable(res_data));
endmodule

// File: tb/hiword_permuter_bench.sv
module hiword_permuter_bench;
  localparam int WORD_W = 16;
  localparam int NL     = 4;
  localparam int DW     = NL * 8 * WORD_W;
  localparam int NW     = NL * 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] src, old_dst, res_data;
  logic [7:0]    imm;
  logic [1:0]    vlen, enc_mode;
  logic          len_bit, mask_en, mask_zero;
  logic [NW-1:0] mask;
  logic [3:0]    rsv_field;
  logic          res_valid, res_illegal;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #5 clk = ~clk;

  hiword_permuter u_hiword_permuter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .old_dst(old_dst),
    .imm(imm), .vlen(vlen), .len_bit(len_bit), .mask(mask), .mask_en(mask_en),
    .mask_zero(mask_zero), .enc_mode(enc_mode), .rsv_field(rsv_field),
    .res_valid(res_valid), .res_data(res_data), .res_illegal(res_illegal)
  );

  function automatic logic [DW-1:0] rnd_vec();
    logic [DW-1:0] v;
    for (int i = 0; i < DW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // reference model built from the requirement text
  function automatic void model(output logic [DW-1:0] d, output logic ill);
    int lanes;
    logic [WORD_W-1:0] w;
    ill = (enc_mode == 2'b11)
       || (enc_mode != 2'b00 && rsv_field != 4'hF)
       || (enc_mode != 2'b00 && vlen == 2'b11)
       || (enc_mode == 2'b01 && vlen == 2'b10)
       || (enc_mode == 2'b01 && vlen == 2'b00 && len_bit);
    if (ill) begin d = old_dst; return; end
    lanes = (enc_mode == 2'b00) ? 1 : (1 << vlen);
    for (int j = 0; j < NW; j++) begin
      int ln = j / 8, wi = j % 8;
      if (ln >= lanes) begin
        w = (enc_mode == 2'b00) ? old_dst[j*WORD_W +: WORD_W] : '0;
      end else begin
        if (wi < 4) w = src[j*WORD_W +: WORD_W];
        else w = src[(ln*8 + 4 + int'(imm[2*(wi-4) +: 2]))*WORD_W +: WORD_W];
        if (enc_mode == 2'b10 && mask_en && !mask[j])
          w = mask_zero ? '0 : old_dst[j*WORD_W +: WORD_W];
      end
      d[j*WORD_W +: WORD_W] = w;
    end
  endfunction

  task automatic check(input string tag, input bit ok, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // present one operation, then check the result one cycle later
  task automatic run_op(input string tag);
    logic [DW-1:0] ed;
    logic          ei;
    model(ed, ei);
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R10 valid"}, res_valid == !ei, DW'(res_valid), DW'(!ei));
    check({tag, " R9 illegal"}, res_illegal == ei, DW'(res_illegal), DW'(ei));
    check({tag, " data"}, res_data === ed, res_data, ed);
  endtask

  task automatic set_op(input logic [1:0] m, input logic [1:0] vl, input logic [7:0] im);
    enc_mode = m; vlen = vl; imm = im;
    src = rnd_vec(); old_dst = rnd_vec();
    mask = NW'({$urandom}); rsv_field = 4'hF; len_bit = 1'b0;
    mask_en = 1'b0; mask_zero = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] held;
    rst_n = 1'b0; in_valid = 1'b0;
    set_op(2'b00, 2'b00, 8'h00);
    repeat (3) @(negedge clk);
    check("R11 reset valid", res_valid == 1'b0, DW'(res_valid), '0);
    check("R11 reset illegal", res_illegal == 1'b0, DW'(res_illegal), '0);
    check("R11 reset data", res_data == '0, res_data, '0);
    rst_n = 1'b1;

    // R5 / R2: legacy, other fields randomised and ignored
    for (int i = 0; i < 256; i++) begin
      set_op(2'b00, 2'($urandom), 8'(i));
      rsv_field = 4'($urandom); len_bit = 1'($urandom);
      mask_en = 1'b1; mask_zero = 1'($urandom);
      run_op("R5 R2 legacy");
    end
    // R1 / R4: zero-extending at 128 and 256 bits
    for (int v = 0; v < 2; v++)
      for (int i = 0; i < 256; i++) begin
        set_op(2'b01, 2'(v), 8'(i));
        if (v == 1) len_bit = 1'($urandom);
        mask_en = 1'($urandom);
        run_op("R1 R4 R7 zext");
      end
    // R3 / R6 / R7: masked mode, all lengths, both mask flavours
    for (int v = 0; v < 3; v++)
      for (int z = 0; z < 2; z++)
        for (int i = 0; i < 256; i++) begin
          set_op(2'b10, 2'(v), 8'(i));
          mask_zero = 1'(z); mask_en = (i % 4) != 0;
          run_op("R3 R6 R7 masked");
        end
    // R3: duplicate selectors, distinct source words
    for (int p = 0; p < 4; p++) begin
      set_op(2'b10, 2'b10, {4{2'(p)}});
      for (int j = 0; j < NW; j++) src[j*WORD_W +: WORD_W] = 16'(16'h100 + j);
      run_op("R3 duplicate");
    end
    // R8 / R9: each illegal combination
    set_op(2'b11, 2'b00, 8'h1B); run_op("R8 mode11");
    set_op(2'b01, 2'b00, 8'h1B); rsv_field = 4'h7; run_op("R8 rsv zext");
    set_op(2'b10, 2'b01, 8'hE4); rsv_field = 4'h0; run_op("R8 rsv masked");
    set_op(2'b10, 2'b11, 8'hE4); run_op("R8 vlen11");
    set_op(2'b01, 2'b10, 8'hE4); run_op("R8 zext512");
    set_op(2'b01, 2'b00, 8'hE4); len_bit = 1'b1; run_op("R8 zext lenbit");
    // R10: idle cycles hold the result and drop the flags
    set_op(2'b10, 2'b10, 8'h39); run_op("R10 pre-idle");
    held = res_data;
    src = rnd_vec(); old_dst = rnd_vec();
    @(negedge clk);
    check("R10 idle valid", res_valid == 1'b0, DW'(res_valid), '0);
    check("R10 idle illegal", res_illegal == 1'b0, DW'(res_illegal), '0);
    check("R10 idle hold", res_data == held, res_data, held);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule